// File: doc/BRIEF.md
# Segment Register Load Checker

This block carries out the load of a 16-bit selector into either the stack segment register or a data segment register, and keeps the hidden copy of that register: selector, base, limit and attribute bits. In real mode, and in virtual-8086 mode, no descriptor is consulted. Only the selector and a paragraph-aligned base are written.

In protected mode the selector is first checked against the limit of the descriptor table. If it is in range, the block reads the 8-byte descriptor over a simple 32-bit read port. It then runs the type and privilege checks that belong to the target register. A failing check ends the load with a fault code. A passing load updates the cached fields.

Each load ends with a one-cycle `done` pulse. The fault code is valid on that pulse and is held until the next load completes.

Top module: `seg_load_checker`

## Requirements
- R1: After reset, `done`, `mem_req` and `fault` are 0, and `seg_sel`, `seg_base`, `seg_limit` and `seg_attr` are all zero.
- R2: A `start` with `pe`=0, or with `vm`=1, raises `done` on the next cycle with fault 0. It sets `seg_sel` to the selector and `seg_base` to the selector times 16. It leaves `seg_limit` and `seg_attr` unchanged and issues no memory read.
- R3: In protected mode, a selector whose byte offset (selector with bits 2:0 cleared) exceeds `tbl_limit` ends the load on the next cycle with fault 1 (general protection). No memory read is issued.
- R4: Otherwise the descriptor is read as two words, low word first. The first read is at `tbl_base` plus the byte offset and the second is 4 bytes higher. Each read holds `mem_req` and `mem_addr` until `mem_rvalid`, and `done` follows the cycle after the second word.
- R5: For a stack target (`ss_target`=1), the load raises fault 1 in each of these cases: a selector offset of zero, a descriptor with bit 44 (S) clear, bit 43 (executable) set, or bit 41 (writable) clear.
- R6: For a stack target, the selector RPL (bits 1:0) must equal the CPL and the descriptor DPL (bits 46:45); otherwise fault 1. The CPL is `cs_rpl`, the low two bits of the code segment selector.
- R7: A stack target whose descriptor has bit 47 (present) clear raises fault 2 (stack fault).
- R8: For a data target, S clear raises fault 1. RPL>DPL together with CPL>DPL raises fault 1. Present clear raises fault 3 (not present). A null selector is not checked for a data target.
- R9: Checks run in the order in which R5–R8 list them for each target, and the first failing check sets the code.
- R10: A passing protected load gives fault 0 and sets `seg_base` from descriptor bits 63:56, 39:32 and 31:16. The 20-bit limit is taken from bits 51:48 and 15:0, and `seg_limit` is that limit shifted left by 12 when bit 55 is set. `seg_attr` is bits 54:52 followed by bits 47:40.
- R11: A load that ends in a fault leaves `seg_sel`, `seg_base`, `seg_limit` and `seg_attr` unchanged.
- R12: `start` is ignored while a descriptor fetch is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (taken when idle) |
| ss_target | input | 1 | 1: stack segment, 0: data segment |
| selector | input | 16 | Selector to load |
| pe | input | 1 | Protected mode enabled |
| vm | input | 1 | Virtual-8086 mode |
| cs_rpl | input | 2 | Low two bits of the code segment selector |
| tbl_base | input | 32 | Descriptor table base address |
| tbl_limit | input | 16 | Descriptor table limit in bytes |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read address |
| mem_rvalid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle load completion pulse |
| fault | output | 2 | 0 none, 1 general protection, 2 stack, 3 not present |
| seg_sel | output | 16 | Cached selector |
| seg_base | output | 32 | Cached base |
| seg_limit | output | 32 | Cached limit |
| seg_attr | output | 11 | Cached attribute bits |

## Verification
Two functions can fall in the same cycle:
- a fresh `start` can arrive while a descriptor fetch is still waiting on a stalled read;
- in a stalled fetch, the second word's `mem_rvalid` lands in the same cycle as the decision that either commits or discards the descriptor.

The bench stalls every other read on chosen vectors. In the middle of a fetch it pulses a real-mode `start`, which would complete in one cycle if accepted. It then checks that the result and the cached fields belong to the original load only, and that exactly two reads were made.

Across the full sweep of descriptor type, present, DPL, RPL and CPL for both targets, each fault code is compared with an order-aware model.

// File: rtl/seg_load_checker.sv
module seg_load_checker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        ss_target,
  input  logic [15:0] selector,
  input  logic        pe,
  input  logic        vm,
  input  logic [1:0]  cs_rpl,
  input  logic [31:0] tbl_base,
  input  logic [15:0] tbl_limit,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic [1:0]  fault,
  output logic [15:0] seg_sel,
  output logic [31:0] seg_base,
  output logic [31:0] seg_limit,
  output logic [10:0] seg_attr
);
  localparam logic [1:0] F_NONE = 2'd0, F_GP = 2'd1, F_SS = 2'd2, F_NP = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} st_t;
  st_t         st;
  logic [15:0] sel_q;
  logic        ss_q;
  logic [1:0]  cpl_q;
  logic [31:0] tbl_q;
  logic [31:0] lo_q;

  wire        busy    = (st != S_IDLE);
  wire [15:0] idx     = {selector[15:3], 3'b000};
  wire        real_md = !pe || vm;
  wire        oob     = idx > tbl_limit;

  assign mem_req  = busy;
  assign mem_addr = tbl_q + {16'h0, sel_q[15:3], 3'b000} + {29'h0, st == S_HI, 2'b00};

  wire [31:0] hi   = mem_rdata;
  wire        d_s  = hi[12];
  wire        d_ex = hi[11];
  wire        d_rw = hi[9];
  wire        d_p  = hi[15];
  wire [1:0]  dpl  = hi[14:13];
  wire [1:0]  rpl  = sel_q[1:0];
  wire [19:0] lim20 = {hi[19:16], lo_q[15:0]};
  wire [31:0] lim32 = hi[23] ? {lim20, 12'h000} : {12'h000, lim20};
  wire [31:0] base32 = {hi[31:24], hi[7:0], lo_q[31:16]};

  logic [1:0] flt;
  always_comb begin
    flt = F_NONE;
    if (ss_q) begin
      if (sel_q[15:3] == 13'd0)               flt = F_GP;
      else if (!d_s)                          flt = F_GP;
      else if (d_ex || !d_rw)                 flt = F_GP;
      else if (rpl != cpl_q || rpl != dpl)    flt = F_GP;
      else if (!d_p)                          flt = F_SS;
    end else begin
      if (!d_s)                               flt = F_GP;
      else if (rpl > dpl && cpl_q > dpl)      flt = F_GP;
      else if (!d_p)                          flt = F_NP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sel_q     <= '0;
      ss_q      <= 1'b0;
      cpl_q     <= '0;
      tbl_q     <= '0;
      lo_q      <= '0;
      done      <= 1'b0;
      fault     <= F_NONE;
      seg_sel   <= '0;
      seg_base  <= '0;
      seg_limit <= '0;
      seg_attr  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (real_md) begin
            seg_sel  <= selector;
            seg_base <= {12'h000, selector, 4'h0};
            fault    <= F_NONE;
            done     <= 1'b1;
          end else if (oob) begin
            fault <= F_GP;
            done  <= 1'b1;
          end else begin
            sel_q <= selector;
            ss_q  <= ss_target;
            cpl_q <= cs_rpl;
            tbl_q <= tbl_base;
            st    <= S_LO;
          end
        end
        S_LO: if (mem_rvalid) begin
          lo_q <= mem_rdata;
          st   <= S_HI;
        end
        S_HI: if (mem_rvalid) begin
          st    <= S_IDLE;
          done  <= 1'b1;
          fault <= flt;
          if (flt == F_NONE) begin
            seg_sel   <= sel_q;
            seg_base  <= base32;
            seg_limit <= lim32;
            seg_attr  <= {hi[22:20], hi[15:8]};
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module seg_load_checker_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        pe,
  input logic        vm,
  input logic [15:0] selector,
  input logic [15:0] tbl_limit,
  input logic        busy,
  input logic        ss_q,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_rvalid,
  input logic        done,
  input logic [1:0]  fault,
  input logic [15:0] seg_sel,
  input logic [31:0] seg_base
);
  p_real_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (!pe || vm) |=> done && fault == 2'd0 && seg_base == {12'h000, $past(selector), 4'h0});

  p_oob_gp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && pe && !vm && ({selector[15:3], 3'b000} > tbl_limit) |=> done && fault == 2'd1 && !mem_req);

  p_hi_follows_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && $past(mem_req) && $past(mem_rvalid) |-> mem_addr == $past(mem_addr) + 32'd4);

  p_no_done_while_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !done);

  p_ss_fault_stack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault == 2'd2 |-> ss_q);

  p_np_fault_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault == 2'd3 |-> !ss_q);

  p_fault_keeps_regs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault != 2'd0 |-> $stable(seg_sel) && $stable(seg_base));

  p_ignore_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy && !mem_rvalid |=> busy);
endmodule

bind seg_load_checker seg_load_checker_sva u_sva (.*);

// File: tb/seg_load_checker_tb.sv
`timescale 1ns/1ps
module seg_load_checker_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, start, ss_target, pe, vm, mem_rvalid;
  logic [15:0] selector, tbl_limit;
  logic [1:0]  cs_rpl;
  logic [31:0] tbl_base, mem_rdata;
  logic        mem_req, done;
  logic [31:0] mem_addr, seg_base, seg_limit;
  logic [1:0]  fault;
  logic [15:0] seg_sel;
  logic [10:0] seg_attr;

  seg_load_checker dut_i (.*);

  int n_chk = 0, n_bad = 0, n_rd = 0;
  logic [31:0] d_lo, d_hi;
  logic        stall_en = 1'b0, phase = 1'b0;
  logic [15:0] e_sel = '0;
  logic [31:0] e_base = '0, e_lim = '0;
  logic [10:0] e_attr = '0;
  bit          finished = 0;

  wire [31:0] lo_addr = tbl_base + {16'h0, selector[15:3], 3'b000};
  assign mem_rvalid = mem_req && (!stall_en || phase);
  assign mem_rdata  = (mem_addr == lo_addr) ? d_lo :
                      (mem_addr == lo_addr + 32'd4) ? d_hi : 32'hBAD0_BAD0;

  always @(negedge clk) phase <= ~phase;
  always @(posedge clk) if (mem_req && mem_rvalid) n_rd <= n_rd + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic do_load();
    int n;
    n_rd = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(done, "R4 done timeout", {31'h0, done}, 32'h1);
  endtask

  function automatic logic [1:0] model(input logic ss, input logic [15:0] sel, input logic [1:0] cpl,
                                       input logic [31:0] hi);
    logic [1:0] dpl = hi[14:13];
    logic [1:0] rpl = sel[1:0];
    if (ss) begin
      if (sel[15:3] == 0) return 2'd1;
      if (!hi[12]) return 2'd1;
      if (hi[11] || !hi[9]) return 2'd1;
      if (rpl != cpl || rpl != dpl) return 2'd1;
      if (!hi[15]) return 2'd2;
      return 2'd0;
    end
    if (!hi[12]) return 2'd1;
    if (rpl > dpl && cpl > dpl) return 2'd1;
    if (!hi[15]) return 2'd3;
    return 2'd0;
  endfunction

  task automatic check_regs(input string tag);
    chk(seg_sel == e_sel, {tag, " sel"}, {16'h0, seg_sel}, {16'h0, e_sel});
    chk(seg_base == e_base, {tag, " base"}, seg_base, e_base);
    chk(seg_limit == e_lim, {tag, " limit"}, seg_limit, e_lim);
    chk(seg_attr == e_attr, {tag, " attr"}, {21'h0, seg_attr}, {21'h0, e_attr});
  endtask

  task automatic real_load(input logic [15:0] sel, input logic pe_i, input logic vm_i);
    selector = sel; pe = pe_i; vm = vm_i;
    do_load();
    e_sel = sel; e_base = {12'h0, sel, 4'h0};
    chk(fault == 2'd0, "R2 real fault", {30'h0, fault}, 0);
    chk(n_rd == 0, "R2 no read", n_rd, 0);
    check_regs("R2");
  endtask

  initial begin
    #(4ns * 150000);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    rst_n = 0; start = 0; ss_target = 0; selector = 0; pe = 0; vm = 0; cs_rpl = 0;
    tbl_base = 32'h0010_0000; tbl_limit = 16'h00FF; d_lo = 0; d_hi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !mem_req && fault == 0, "R1 reset outputs", {29'h0, done, fault}, 0);
    check_regs("R1");

    real_load(16'h1234, 1'b0, 1'b0);
    real_load(16'hFFFF, 1'b1, 1'b1);
    real_load(16'h0008, 1'b0, 1'b1);

    pe = 1; vm = 0; tbl_limit = 16'h0017;
    selector = 16'h0018; ss_target = 0;
    do_load();
    chk(fault == 2'd1, "R3 index past limit", {30'h0, fault}, 1);
    chk(n_rd == 0, "R3 no read", n_rd, 0);
    check_regs("R11 after R3");
    tbl_limit = 16'h001F; selector = 16'h001B; cs_rpl = 0;
    d_lo = 32'hABCD_1111; d_hi = 32'h12C0_F256;
    do_load();
    chk(n_rd == 2, "R4 two reads at limit edge", n_rd, 2);
    chk(fault == 2'd0, "R3 offset equal to limit range ok", {30'h0, fault}, 0);
    e_sel = 16'h001B; e_base = 32'h1256_ABCD; e_lim = {20'h01111, 12'h000}; e_attr = {3'b100, 8'hF2};
    check_regs("R10 granular");

    tbl_limit = 16'h00FF;
    for (int v = 0; v < 2048; v++) begin
      logic [31:0] lo, hi;
      logic [1:0] ef;
      logic [19:0] l20;
      logic g;
      g = v[1] ^ v[4];
      ss_target = v[0];
      selector = {10'h0, 3'((v * 5) % 8), 1'b0, 2'(v >> 7)};
      cs_rpl = 2'(v >> 9);
      lo = 32'h1357_0000 ^ (v * 32'h0001_0003);
      hi = {8'(v) ^ 8'h5A, g, v[2], v[8], v[9], 4'(v) ^ 4'h9, v[4], 2'(v >> 5), v[1], v[2], v[5], v[3], v[6],
            8'(v >> 3)};
      d_lo = lo; d_hi = hi;
      tbl_base = 32'h0002_0000 + 32'(v) * 32'h40;
      stall_en = v[0] ^ v[3];
      do_load();
      ef = model(v[0], selector, cs_rpl, hi);
      chk(n_rd == 2, "R4 read count", n_rd, 2);
      chk(fault == ef, v[0] ? "R5/R6/R7/R9 stack fault" : "R8/R9 data fault", {30'h0, fault}, {30'h0, ef});
      if (ef == 2'd0) begin
        l20 = {hi[19:16], lo[15:0]};
        e_sel = selector; e_base = {hi[31:24], hi[7:0], lo[31:16]};
        e_lim = g ? {l20, 12'h000} : {12'h000, l20};
        e_attr = {hi[22:20], hi[15:8]};
        check_regs("R10");
      end else begin
        check_regs("R11");
      end
    end

    stall_en = 1; ss_target = 0; selector = 16'h0030; cs_rpl = 0; tbl_base = 32'h0040_0000;
    d_lo = 32'h2222_3333; d_hi = 32'h0040_F300;
    n_rd = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b1; selector = 16'h0030; pe = 0;
    @(negedge clk);
    start = 1'b0; pe = 1;
    while (!done) @(negedge clk);
    chk(fault == 2'd0 && n_rd == 2, "R12 start ignored mid fetch", {n_rd[29:0], fault}, {30'd2, 2'd0});
    e_sel = 16'h0030; e_base = 32'h0000_2222; e_lim = 32'h0000_3333; e_attr = {3'b100, 8'hF3};
    check_regs("R12");
    @(negedge clk);
    chk(!done, "R12 no extra completion", {31'h0, done}, 0);

    summary();
  end
endmodule